// File: doc/BRIEF.md
# Command-List Control and Halt-Interrupt Register Block

This block is a small register file placed next to a command-list execution engine. It keeps a hold control that can stall the engine's external memory references, a copy of the engine's run state, a sticky flag recording that the command list stopped, and an enable that turns that flag into an interrupt request. A processor core reaches all of it through a simple single-cycle register bus with a select, a write flag, an address and write data. Read data is returned combinationally in the same cycle.

On the engine side, the block sees the run level, a one-cycle halt pulse and an external-reference request. It returns a grant, which stays low while the hold control is set. A write to the abort offset clears the hold control, the halt flag and the interrupt enable together. A read of the halt flag returns its value and then clears it.

Top module: `cl_ctrl_regs`

## Requirements
- R1: `eng_xgnt` equals `eng_xreq` while the hold bit is 0. While the hold bit is 1, a pending request sees `eng_xgnt` low in every cycle. The grant appears in the first cycle after the hold bit returns to 0.
- R2: A write to offset 0 loads the hold bit from `bus_wdata[0]`, taking effect on the next clock edge. A read of offset 0 returns the hold bit in bit 0 and zeros in bits 15:1.
- R3: A write to offset 4 (abort) clears the hold bit, the halt flag and the interrupt enable on the next clock edge. Its write data is ignored.
- R4: A read of offset 1 returns in bit 0 the value `eng_run` had at the previous clock edge. Writes to offset 1 have no effect.
- R5: A pulse on `eng_halt` sets the halt flag on that clock edge. The flag then stays 1 until something clears it.
- R6: A read of offset 2 returns the halt flag in bit 0 and clears the flag at that clock edge. If a halt pulse arrives in the same cycle as that read, the flag stays set. Writes to offset 2 have no effect.
- R7: The interrupt enable is written and read at offset 3, bit 0, where 1 means enabled. `irq` is high exactly when both the halt flag and the enable are 1.
- R8: After reset, the hold bit, the run copy, the halt flag and the enable are all 0, and `irq` is low.
- R9: Reads of offsets 4 to 7 return 0, writes to offsets 5 to 7 change nothing, and `bus_rdata` is 0 in any cycle without a read.
- R10: When an abort write and a halt pulse fall in the same cycle, the abort wins and the halt flag is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| eng_run | input | 1 | Engine is executing the command list |
| eng_halt | input | 1 | One-cycle pulse when execution stops |
| eng_xreq | input | 1 | Engine requests an external memory reference |
| eng_xgnt | output | 1 | External reference allowed |
| irq | output | 1 | Halt interrupt request |

## Verification
Two pairs of events can fall in the same cycle. A halt pulse can coincide with a clearing read of the halt flag, and it can coincide with an abort write. Directed cycles provoke each pair on purpose, and the random phase produces them often because it drives halt pulses and accesses to offsets 2 and 4 independently. Each cycle, a bench model applies the ordering the requirements give (abort first, then the halt set, then the read clear), and the bench judges the design by what later reads of offset 2 and the level of `irq` show.

// File: rtl/cl_regs_pkg.sv
package cl_regs_pkg;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned N_REG   = 5;
    // offsets double as decoder indices
    localparam int unsigned IDX_HOLD  = 0;
    localparam int unsigned IDX_STAT  = 1;
    localparam int unsigned IDX_HALT  = 2;
    localparam int unsigned IDX_MASK  = 3;
    localparam int unsigned IDX_ABORT = 4;

    typedef struct packed {
        logic hold;
    } hold_st_t;

    typedef struct packed {
        logic halt;
        logic mask;
    } halt_st_t;

    typedef struct packed {
        logic run;
    } run_st_t;
endpackage

// File: rtl/cl_addr_dec.sv
module cl_addr_dec #(
    parameter int unsigned ADDR_W = cl_regs_pkg::ADDR_W,
    parameter int unsigned N_REG  = cl_regs_pkg::N_REG
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_REG-1:0]  wr_hit,
    output logic [N_REG-1:0]  rd_hit
);
    for (genvar i = 0; i < N_REG; i++) begin : g_slot
        logic match;
        assign match     = (addr == ADDR_W'(i));
        assign wr_hit[i] = sel & wr & match;
        assign rd_hit[i] = sel & ~wr & match;
    end
endmodule

// File: rtl/cl_hold_gate.sv
module cl_hold_gate
    import cl_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wbit,
    input  logic abort,
    input  logic xreq,
    output logic hold_q,
    output logic xgnt
);
    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (abort) begin
            st_d.hold = 1'b0;
        end else if (wr_en) begin
            st_d.hold = wbit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_q = st_q.hold;
    assign xgnt   = xreq & ~st_q.hold;
endmodule

// File: rtl/cl_halt_irq.sv
module cl_halt_irq
    import cl_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_ev,
    input  logic rd_clr,
    input  logic mask_wr,
    input  logic mask_bit,
    input  logic abort,
    output logic halt_q,
    output logic mask_q,
    output logic irq
);
    halt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // order: abort, then halt set, then read clear
        if (abort) begin
            st_d.halt = 1'b0;
            st_d.mask = 1'b0;
        end else begin
            if (halt_ev) begin
                st_d.halt = 1'b1;
            end else if (rd_clr) begin
                st_d.halt = 1'b0;
            end
            if (mask_wr) begin
                st_d.mask = mask_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign halt_q = st_q.halt;
    assign mask_q = st_q.mask;
    assign irq    = st_q.halt & st_q.mask;
endmodule

// File: rtl/cl_ctrl_regs.sv
module cl_ctrl_regs
    import cl_regs_pkg::*;
#(
    parameter int unsigned DW = cl_regs_pkg::DATA_W,
    parameter int unsigned AW = cl_regs_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          eng_run,
    input  logic          eng_halt,
    input  logic          eng_xreq,
    output logic          eng_xgnt,
    output logic          irq
);
    logic [N_REG-1:0] wr_hit;
    logic [N_REG-1:0] rd_hit;
    logic             hold_q;
    logic             halt_q;
    logic             mask_q;
    logic             run_q;
    logic             abort;
    logic             unused_wdata;
    run_st_t          st_d, st_q;

    assign unused_wdata = ^bus_wdata[DW-1:1];
    assign abort        = wr_hit[IDX_ABORT];

    cl_addr_dec #(.ADDR_W(AW), .N_REG(N_REG)) u_dec (
        .sel    (bus_sel),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    cl_hold_gate u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_hit[IDX_HOLD]),
        .wbit   (bus_wdata[0]),
        .abort  (abort),
        .xreq   (eng_xreq),
        .hold_q (hold_q),
        .xgnt   (eng_xgnt)
    );

    cl_halt_irq u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_ev  (eng_halt),
        .rd_clr   (rd_hit[IDX_HALT]),
        .mask_wr  (wr_hit[IDX_MASK]),
        .mask_bit (bus_wdata[0]),
        .abort    (abort),
        .halt_q   (halt_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    always_comb begin
        st_d     = st_q;
        st_d.run = eng_run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_q = st_q.run;

    always_comb begin
        bus_rdata = '0;
        unique case (1'b1)
            rd_hit[IDX_HOLD]: bus_rdata[0] = hold_q;
            rd_hit[IDX_STAT]: bus_rdata[0] = run_q;
            rd_hit[IDX_HALT]: bus_rdata[0] = halt_q;
            rd_hit[IDX_MASK]: bus_rdata[0] = mask_q;
            default:          bus_rdata    = '0;
        endcase
    end
endmodule

// File: rtl/cl_ctrl_regs_chk.sv
module cl_ctrl_regs_chk
    import cl_regs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             eng_run,
    input logic             eng_halt,
    input logic             eng_xreq,
    input logic             eng_xgnt,
    input logic             irq,
    input logic             hold_q,
    input logic             halt_q,
    input logic             mask_q,
    input logic             run_q,
    input logic [N_REG-1:0] wr_hit,
    input logic [N_REG-1:0] rd_hit
);
    p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_xreq && hold_q) |-> !eng_xgnt);

    p_abort_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit[IDX_ABORT] |=> (!hold_q && !halt_q && !mask_q));

    p_run_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (run_q == $past(eng_run)));

    p_halt_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_halt && !wr_hit[IDX_ABORT]) |=> halt_q);

    p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit[IDX_HALT] && !eng_halt && !wr_hit[IDX_ABORT]) |=> !halt_q);

    p_irq_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q |-> !irq);

    p_dec_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit | rd_hit));

    p_abort_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_halt && wr_hit[IDX_ABORT]) |=> !halt_q);
endmodule

bind cl_ctrl_regs cl_ctrl_regs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .eng_run  (eng_run),
    .eng_halt (eng_halt),
    .eng_xreq (eng_xreq),
    .eng_xgnt (eng_xgnt),
    .irq      (irq),
    .hold_q   (hold_q),
    .halt_q   (halt_q),
    .mask_q   (mask_q),
    .run_q    (run_q),
    .wr_hit   (wr_hit),
    .rd_hit   (rd_hit)
);

// File: tb/sim_cl_ctrl_regs.sv
`timescale 1ns/1ps
module sim_cl_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        eng_run = 1'b0;
    logic        eng_halt = 1'b0;
    logic        eng_xreq = 1'b0;
    logic        eng_xgnt;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic m_hold = 0, m_run = 0, m_halt = 0, m_mask = 0;

    always #2 clk = ~clk;

    cl_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_run(eng_run), .eng_halt(eng_halt), .eng_xreq(eng_xreq),
        .eng_xgnt(eng_xgnt), .irq(irq)
    );

    function automatic logic [15:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return {15'b0, m_hold};
            3'd1:    return {15'b0, m_run};
            3'd2:    return {15'b0, m_halt};
            3'd3:    return {15'b0, m_mask};
            default: return 16'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0:    return "R2";
            3'd1:    return "R4";
            3'd2:    return "R6";
            3'd3:    return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic w, input logic [2:0] a,
                       input logic [15:0] d, input logic r, input logic h,
                       input logic x, input string tag);
        logic [15:0] er;
        logic        ab;
        string       t;
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        eng_run = r; eng_halt = h; eng_xreq = x;
        #1;
        t  = (tag == "") ? tag_of(a) : tag;
        er = (s && !w) ? exp_read(a) : 16'h0;
        chk(bus_rdata == er, (s && !w) ? t : "R9", "rdata", bus_rdata, er);
        chk(eng_xgnt == (x & ~m_hold), "R1", "xgnt", eng_xgnt, x & ~m_hold);
        chk(irq == (m_halt & m_mask), "R7", "irq", irq, m_halt & m_mask);
        @(posedge clk);
        ab = s && w && a == 3'd4;
        m_run = r;
        if (ab) begin
            m_hold = 0; m_halt = 0; m_mask = 0;
        end else begin
            if (s && w && a == 3'd0) m_hold = d[0];
            if (s && w && a == 3'd3) m_mask = d[0];
            if (h) m_halt = 1;
            else if (s && !w && a == 3'd2) m_halt = 0;
        end
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        cyc(1, 0, a, 16'h0, 0, 0, 0, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cyc(1, 1, a, d, 0, 0, 0, "");
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        chk(irq == 1'b0, "R8", "irq in reset", irq, 0);
        chk(bus_rdata == 16'h0, "R8", "rdata in reset", bus_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) rd(3'(i), "R8");

        // hold write/read, reserved bits
        wr(3'd0, 16'hFFFF);
        rd(3'd0, "R2");
        cyc(0, 0, 0, 0, 0, 0, 1, "R1");
        cyc(0, 0, 0, 0, 0, 0, 1, "R1");
        cyc(1, 1, 3'd0, 16'hFFFE, 0, 0, 1, "R1");
        cyc(0, 0, 0, 0, 0, 0, 1, "R1");

        // run copy, writes ignored
        cyc(0, 0, 0, 0, 1, 0, 0, "R4");
        rd(3'd1, "R4");
        cyc(1, 1, 3'd1, 16'h0000, 1, 0, 0, "R4");
        rd(3'd1, "R4");
        rd(3'd1, "R4");

        // halt set, irq, read clear
        wr(3'd3, 16'h0001);
        cyc(0, 0, 0, 0, 0, 1, 0, "R5");
        cyc(0, 0, 0, 0, 0, 0, 0, "R5");
        cyc(1, 1, 3'd2, 16'h0000, 0, 0, 0, "R6");
        rd(3'd2, "R6");
        rd(3'd2, "R6");
        // read and halt in same cycle
        cyc(0, 0, 0, 0, 0, 1, 0, "R6");
        cyc(1, 0, 3'd2, 0, 0, 1, 0, "R6");
        rd(3'd2, "R6");

        // abort clears everything
        wr(3'd0, 16'h0001);
        cyc(0, 0, 0, 0, 0, 1, 1, "R3");
        cyc(1, 1, 3'd4, 16'hFFFF, 0, 0, 1, "R3");
        rd(3'd0, "R3"); rd(3'd2, "R3"); rd(3'd3, "R3");

        // abort and halt together
        wr(3'd3, 16'h0001);
        cyc(1, 1, 3'd4, 16'h0000, 0, 1, 0, "R10");
        rd(3'd2, "R10");

        // unmapped offsets
        wr(3'd0, 16'h0001); wr(3'd3, 16'h0001);
        wr(3'd5, 16'h0000); wr(3'd6, 16'h0000); wr(3'd7, 16'h0000);
        for (int i = 4; i < 8; i++) rd(3'(i), "R9");
        rd(3'd0, "R9"); rd(3'd3, "R9");

        for (int i = 0; i < 4000; i++) begin
            logic s, w, r, h, x;
            logic [2:0]  a;
            logic [15:0] d;
            s = ($urandom % 3) != 0;
            w = $urandom % 2;
            a = ($urandom % 5 == 0) ? 3'($urandom % 8) : 3'($urandom % 5);
            d = 16'($urandom);
            r = $urandom % 2;
            h = ($urandom % 4) == 0;
            x = $urandom % 2;
            cyc(s, w, a, d, r, h, x, "");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule